// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the master side of a two-wire management link to an Ethernet PHY. A host asks for one transaction by raising `start` for a cycle while the block is idle. With the request it gives a read-or-write flag, a 5-bit PHY address, a 5-bit register number and, for a write, 16 bits of data. The block then builds the whole serial frame by itself and runs it out on the management clock and data lines. It shows `busy` for the whole frame and pulses `done` for one cycle when the line is back at rest. After a read, the 16 captured bits wait on `rd_data` until the next read.

The management clock is made from the system clock. Each half of the management clock lasts `CLK_DIV+1` system clocks, so one bit time is `2*(CLK_DIV+1)` system clocks. Each bit is set up while the management clock is low and held through the high half that follows. Read data is taken at the end of that high half. A frame always has 65 bit times:
- 32 preamble ones;
- a two-bit start code;
- a two-bit opcode;
- the PHY address;
- the register number;
- two turnaround bits;
- 16 data bits;
- one closing bit with the line released.

Top module: `mdio_master`

## Requirements
- R1: After reset, and at all times while `busy` is low, `mdc`, `mdio_o` and `mdio_oe` are 0. After reset, `busy`, `done` and `rd_data` are 0.
- R2: Bit times 0 to 31 of every frame carry a 1 with `mdio_oe` high.
- R3: Bit times 32 and 33 carry 0 then 1, both driven. Bit times 34 and 35 carry 1,0 for a read (`wr_op`=0) and 0,1 for a write (`wr_op`=1), both driven.
- R4: Bit times 36 to 40 carry `phy_addr` bits 4 down to 0, and bit times 41 to 45 carry `reg_addr` bits 4 down to 0. All ten are driven.
- R5: Bit times 46 and 47 (turnaround) have `mdio_oe` low and `mdio_o` low, for both reads and writes.
- R6: On a write, bit times 48 to 63 carry `wr_data` bits 15 down to 0 with `mdio_oe` high.
- R7: On a read, bit times 48 to 63 have `mdio_oe` low. `mdio_i` is sampled at the last system clock of each of these bits' high half, and the samples go into `rd_data` MSB first. `mdio_i` at any other time has no effect. After a write, `rd_data` still holds its earlier value.
- R8: Within a frame, each bit time is `CLK_DIV+1` system clocks with `mdc` low followed by `CLK_DIV+1` clocks with `mdc` high. `mdio_o` and `mdio_oe` change only at bit boundaries.
- R9: Bit time 64 has `mdc` toggling with `mdio_oe` and `mdio_o` low. The frame then ends, with the line idle as in R1.
- R10: `done` is high for exactly one cycle. It is first visible `65*2*(CLK_DIV+1)` cycles after the edge that accepted `start`, and it appears together with `busy` falling.
- R11: `start` while `busy` is high is ignored. The frame in flight is unchanged, and no further frame follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| wr_op | input | 1 | 1 = write transaction, 0 = read |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register number |
| wr_data | input | 16 | Data for a write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Last read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Frames are run with two kinds of address patterns:
- all-zero and all-one addresses, which would expose a stuck or reversed field;
- mixed addresses, which show whether the PHY and register fields are swapped.

Writes use the values 8001 and 5A3C, which separate MSB-first order from LSB-first order. Reads return A5C3, 0000 and FFFF. While no data bits are expected, `mdio_i` toggles every cycle, which would show a capture made in the wrong bit time or on the wrong half. A second `start` in the middle of a frame, carrying different fields, shows whether a request is wrongly taken while busy.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned ADR_W    = 5;
  localparam int unsigned DAT_W    = 16;
  localparam int unsigned PRE_BITS = 32;

  // bit-time positions of each field inside a frame
  localparam int unsigned POS_ST   = PRE_BITS;
  localparam int unsigned POS_OP   = POS_ST + 2;
  localparam int unsigned POS_PHY  = POS_OP + 2;
  localparam int unsigned POS_REG  = POS_PHY + ADR_W;
  localparam int unsigned POS_TA   = POS_REG + ADR_W;
  localparam int unsigned POS_DAT  = POS_TA + 2;
  localparam int unsigned POS_END  = POS_DAT + DAT_W;
  localparam int unsigned FRAME_BITS = POS_END + 1;
  localparam int unsigned IDX_W    = $clog2(FRAME_BITS);

  typedef logic [IDX_W-1:0] bit_idx_t;

  typedef enum logic {OP_RD = 1'b0, OP_WR = 1'b1} mdio_op_e;

  typedef struct packed {
    mdio_op_e           op;
    logic [ADR_W-1:0]   phy;
    logic [ADR_W-1:0]   regn;
    logic [DAT_W-1:0]   wdata;
  } mdio_req_t;

  // does the master own the line during this bit time
  function automatic logic drives_line(bit_idx_t idx, mdio_op_e op);
    int unsigned i;
    i = 32'(idx);
    if (i < POS_TA) return 1'b1;
    if (i >= POS_DAT && i < POS_END) return (op == OP_WR);
    return 1'b0;
  endfunction

  // is this bit time one whose sample lands in the read result
  function automatic logic captures_bit(bit_idx_t idx, mdio_op_e op);
    int unsigned i;
    i = 32'(idx);
    return (op == OP_RD) && (i >= POS_DAT) && (i < POS_END);
  endfunction

  // value presented on the data line for a bit time
  function automatic logic frame_bit(bit_idx_t idx, mdio_req_t rq);
    int unsigned i;
    logic [ADR_W-1:0] a;
    logic [DAT_W-1:0] d;
    i = 32'(idx);
    if (i < POS_ST)     return 1'b1;
    if (i == POS_ST)    return 1'b0;
    if (i == POS_ST+1)  return 1'b1;
    if (i == POS_OP)    return (rq.op == OP_RD);
    if (i == POS_OP+1)  return (rq.op == OP_WR);
    if (i < POS_REG) begin
      a = rq.phy >> (ADR_W - 1 - (i - POS_PHY));
      return a[0];
    end
    if (i < POS_TA) begin
      a = rq.regn >> (ADR_W - 1 - (i - POS_REG));
      return a[0];
    end
    if (i >= POS_DAT && i < POS_END && rq.op == OP_WR) begin
      d = rq.wdata >> (DAT_W - 1 - (i - POS_DAT));
      return d[0];
    end
    return 1'b0;
  endfunction
endpackage

// File: rtl/mdio_phase_gen.sv
module mdio_phase_gen #(
  parameter int unsigned CLK_DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc_hi,
  output logic lo_end,
  output logic hi_end
);
  localparam int unsigned CNT_W = (CLK_DIV < 1) ? 1 : $clog2(CLK_DIV + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV);

  logic [CNT_W-1:0] cnt;
  logic             half_hi;
  logic             half_last;

  assign half_last = run && (cnt == CNT_LAST);
  assign lo_end    = half_last && !half_hi;
  assign hi_end    = half_last && half_hi;
  assign mdc_hi    = half_hi;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt     <= '0;
      half_hi <= 1'b0;
    end else if (half_last) begin
      cnt     <= '0;
      half_hi <= !half_hi;
    end else begin
      cnt     <= cnt + CNT_W'(1);
    end
  end

  // R8
  one_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lo_end, hi_end}));
  // R8
  half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !half_last) |=> $stable(mdc_hi));
  // R8
  half_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && half_last) |=> (mdc_hi != $past(mdc_hi)));
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  mdio_req_t req_in,
  input  logic      hi_end,
  output logic      busy,
  output logic      done,
  output bit_idx_t  idx,
  output mdio_req_t req_q
);
  localparam bit_idx_t IDX_LAST = bit_idx_t'(POS_END);

  logic accept;
  logic last_bit_end;

  assign accept       = start && !busy;
  assign last_bit_end = busy && hi_end && (idx == IDX_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      idx   <= '0;
      req_q <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        idx   <= '0;
        req_q <= req_in;
      end else if (last_bit_end) begin
        busy <= 1'b0;
        done <= 1'b1;
        idx  <= '0;
      end else if (busy && hi_end) begin
        idx <= idx + bit_idx_t'(1);
      end
    end
  end

  // R11
  busy_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(req_q));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R8
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hi_end) |=> $stable(idx));
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture_en,
  input  logic          mdi,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n)          rdata <= '0;
    else if (capture_en) rdata <= {rdata[DW-2:0], mdi};
  end

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_en |=> $stable(rdata));
  // R7
  rd_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> (rdata[0] == $past(mdi)));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned CLK_DIV = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_op,
  input  logic [ADR_W-1:0]  phy_addr,
  input  logic [ADR_W-1:0]  reg_addr,
  input  logic [DAT_W-1:0]  wr_data,
  output logic              busy,
  output logic              done,
  output logic [DAT_W-1:0]  rd_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  mdio_req_t req_in;
  mdio_req_t req_q;
  bit_idx_t  idx;
  logic      mdc_hi;
  logic      lo_end;
  logic      hi_end;
  logic      drive_now;
  logic      capture_en;

  assign req_in.op    = wr_op ? OP_WR : OP_RD;
  assign req_in.phy   = phy_addr;
  assign req_in.regn  = reg_addr;
  assign req_in.wdata = wr_data;

  mdio_phase_gen #(.CLK_DIV(CLK_DIV)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy),
    .mdc_hi (mdc_hi),
    .lo_end (lo_end),
    .hi_end (hi_end)
  );

  mdio_frame_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .req_in (req_in),
    .hi_end (hi_end),
    .busy   (busy),
    .done   (done),
    .idx    (idx),
    .req_q  (req_q)
  );

  assign drive_now  = busy && drives_line(idx, req_q.op);
  assign capture_en = busy && hi_end && captures_bit(idx, req_q.op);

  mdio_rx_capture #(.DW(DAT_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_en (capture_en),
    .mdi        (mdio_i),
    .rdata      (rd_data)
  );

  assign mdc     = busy && mdc_hi;
  assign mdio_oe = drive_now;
  assign mdio_o  = drive_now && frame_bit(idx, req_q);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_o && !mdio_oe));
  // R8
  data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hi_end) |=> ($stable(mdio_o) && $stable(mdio_oe)));
  // R2
  preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (32'(idx) < PRE_BITS)) |-> (mdio_oe && mdio_o));
  // R5
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (32'(idx) >= POS_TA) && (32'(idx) < POS_DAT)) |-> (!mdio_oe && !mdio_o));
  // R9
  last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (32'(idx) == POS_END)) |-> !mdio_oe);
  // R7
  lo_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_end |-> !capture_en);
endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  localparam int DIV = 2;
  localparam int H   = DIV + 1;
  localparam int BT  = 2 * H;
  localparam int NB  = 65;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wr_op = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic        mdio_i = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mdio_master #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_op(wr_op),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int b);
    if (b < 32) return "R2";
    if (b < 36) return "R3";
    if (b < 46) return "R4";
    if (b < 48) return "R5";
    if (b < 64) return "R6/R7";
    return "R9";
  endfunction

  task automatic run_frame(input bit wr, input logic [4:0] ph, input logic [4:0] rg,
                           input logic [15:0] wd, input logic [15:0] rp, input bit poke);
    int eo [NB];
    int eoe [NB];
    int k;
    logic [15:0] prev_rd;
    k = 0;
    repeat (32) begin eo[k] = 1; eoe[k] = 1; k++; end
    eo[k] = 0; eoe[k] = 1; k++;
    eo[k] = 1; eoe[k] = 1; k++;
    eo[k] = wr ? 0 : 1; eoe[k] = 1; k++;
    eo[k] = wr ? 1 : 0; eoe[k] = 1; k++;
    for (int j = 4; j >= 0; j--) begin eo[k] = int'(ph[j]); eoe[k] = 1; k++; end
    for (int j = 4; j >= 0; j--) begin eo[k] = int'(rg[j]); eoe[k] = 1; k++; end
    repeat (2) begin eo[k] = 0; eoe[k] = 0; k++; end
    for (int j = 15; j >= 0; j--) begin
      eo[k]  = wr ? int'(wd[j]) : 0;
      eoe[k] = wr ? 1 : 0;
      k++;
    end
    eo[k] = 0; eoe[k] = 0;

    prev_rd = rd_data;
    @(negedge clk);
    wr_op = wr; phy_addr = ph; reg_addr = rg; wr_data = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < NB * BT; n++) begin
      int b;
      bit hi;
      b  = n / BT;
      hi = (n % BT) >= H;
      if (!wr && b >= 48 && b < 64) mdio_i = rp[15 - (b - 48)];
      else mdio_i = n[0];
      if (poke && n == 200) begin
        start = 1'b1; wr_op = ~wr; phy_addr = ~ph; reg_addr = ~rg; wr_data = ~wd;
      end
      if (poke && n == 201) start = 1'b0;
      chk(mdc == hi, "R8", "mdc phase", int'(mdc), int'(hi));
      chk(int'(mdio_oe) == eoe[b], tag_of(b), $sformatf("oe bit %0d", b), int'(mdio_oe), eoe[b]);
      chk(int'(mdio_o) == eo[b], tag_of(b), $sformatf("data bit %0d", b), int'(mdio_o), eo[b]);
      chk(busy && !done, "R10", "busy mid-frame", int'({busy, done}), 2);
      @(negedge clk);
    end
    mdio_i = 1'b0;
    chk(done == 1'b1, "R10", "done at end", int'(done), 1);
    chk(busy == 1'b0, "R10", "busy falls with done", int'(busy), 0);
    chk({mdc, mdio_o, mdio_oe} == 3'b000, "R9", "idle after frame", int'({mdc, mdio_o, mdio_oe}), 0);
    if (wr) chk(rd_data == prev_rd, "R7", "rd_data kept over write", int'(rd_data), int'(prev_rd));
    else    chk(rd_data == rp, "R7", "read result", int'(rd_data), int'(rp));
    @(negedge clk);
    chk(done == 1'b0, "R10", "done one cycle", int'(done), 0);
    repeat (BT) begin
      chk(busy == 1'b0 && mdc == 1'b0, "R11", "no extra frame", int'({busy, mdc}), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, mdc, mdio_o, mdio_oe} == 5'b0, "R1", "reset outputs",
        int'({busy, done, mdc, mdio_o, mdio_oe}), 0);
    chk(rd_data == 16'h0, "R1", "reset rd_data", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, mdc, mdio_o, mdio_oe} == 5'b0, "R1", "idle after reset",
        int'({busy, done, mdc, mdio_o, mdio_oe}), 0);
    run_frame(1'b0, 5'h00, 5'h01, 16'h0000, 16'hA5C3, 1'b0);
    run_frame(1'b1, 5'h1F, 5'h00, 16'h8001, 16'h0000, 1'b0);
    run_frame(1'b0, 5'h15, 5'h0A, 16'h1234, 16'h0000, 1'b0);
    run_frame(1'b0, 5'h0A, 5'h15, 16'h0000, 16'hFFFF, 1'b1);
    run_frame(1'b1, 5'h03, 5'h1C, 16'h5A3C, 16'h0000, 1'b1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule